// File: doc/BRIEF.md
# Unified data-space address decoder

This block sits between the requesters of an 8-bit microcontroller (the CPU or a DMA engine, already arbitrated) and the physical stores behind its 16-bit external data space. Each access carries an address, a read/write strobe and write data. The block decides which store the access belongs to: on-chip SRAM, a 1 KB extended peripheral register window, the special-function register window, a read-only device information page, or a 32 KB window onto one flash bank chosen by a 3-bit bank selector. For the chosen store it drives a select, a local address and, where writing is allowed, a write enable.

Read data comes back one clock after the request. The block registers the decoded region with the request, so that it can pick the matching store's synchronous read data in the next cycle. Addresses that map to no store read as 0x00 and do not respond to writes. Writes to the information page or to the flash window are dropped without any target activity. A second, 8-bit internal-data port reaches the top 256 bytes of SRAM through a dedicated SRAM port. If `SRAM_SIZE` is set so large that SRAM would run into the peripheral window, or below 256 bytes, elaboration stops with an error.

Top module: `data_space_decoder`

## Requirements
- R1: An access with address below SRAM_SIZE asserts sram_sel_o with sram_addr_o equal to the address. A write also asserts sram_we_o, and a read returns the stored byte.
- R2: Addresses 0x6000 to 0x63FF assert per_sel_o with per_addr_o equal to address bits [9:0]. per_we_o is asserted on writes.
- R3: Addresses 0x7080 to 0x70FF assert sfr_sel_o with sfr_addr_o equal to address bits [6:0]. sfr_we_o is asserted on writes.
- R4: A read of addresses 0x7800 to 0x7FFF asserts info_sel_o with info_addr_o equal to address bits [10:0] and returns the page byte.
- R5: A read of addresses 0x8000 to 0xFFFF asserts flash_sel_o with flash_addr_o equal to {bank_i, address[14:0]}. Every bank value 0 to 7 reaches its own bank.
- R6: Addresses in the holes (SRAM_SIZE to 0x5FFF, 0x6400 to 0x707F, 0x7100 to 0x77FF) assert no select and no write enable. A read there returns rdata_o = 0x00 with rvalid_o = 1.
- R7: A write to 0x7800 or above asserts no select and no write enable. A later read of the same address returns the unchanged byte.
- R8: An internal-data access to address A drives sram_b_sel_o with sram_b_addr_o = SRAM_SIZE-256+A. sram_b_we_o is asserted on writes. A read returns the byte on idat_rdata_o one clock later. Bytes are shared with the main port at the aliased SRAM address.
- R9: rvalid_o is 1 exactly one clock after a read request, and rdata_o then holds that read's byte. In every other cycle rvalid_o is 0 and rdata_o is 0x00. Back-to-back reads return their bytes in consecutive cycles.
- R10: At most one of the five target selects is active in any cycle. No select is active while req_i is low. During reset rvalid_o, rdata_o, idat_rvalid_o and idat_rdata_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Main access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 16 | Data-space address |
| wdata_i | input | 8 | Write data |
| bank_i | input | BANK_W | Flash bank shown in the upper half |
| rvalid_o | output | 1 | Read data valid (one clock after a read) |
| rdata_o | output | 8 | Read data, 0 when not valid |
| idat_req_i | input | 1 | Internal-data request |
| idat_we_i | input | 1 | Internal-data write |
| idat_addr_i | input | 8 | Internal-data address |
| idat_wdata_i | input | 8 | Internal-data write data |
| idat_rvalid_o | output | 1 | Internal-data read valid |
| idat_rdata_o | output | 8 | Internal-data read data |
| wdata_o | output | 8 | Write data to targets |
| sram_sel_o | output | 1 | SRAM port A select |
| sram_we_o | output | 1 | SRAM port A write enable |
| sram_addr_o | output | SRAM_AW | SRAM port A address |
| sram_rdata_i | input | 8 | SRAM port A read data |
| sram_b_sel_o | output | 1 | SRAM port B select |
| sram_b_we_o | output | 1 | SRAM port B write enable |
| sram_b_addr_o | output | SRAM_AW | SRAM port B address |
| sram_b_wdata_o | output | 8 | SRAM port B write data |
| sram_b_rdata_i | input | 8 | SRAM port B read data |
| per_sel_o | output | 1 | Peripheral window select |
| per_we_o | output | 1 | Peripheral window write enable |
| per_addr_o | output | 10 | Peripheral window offset |
| per_rdata_i | input | 8 | Peripheral window read data |
| sfr_sel_o | output | 1 | Special-function window select |
| sfr_we_o | output | 1 | Special-function window write enable |
| sfr_addr_o | output | 7 | Special-function window offset |
| sfr_rdata_i | input | 8 | Special-function read data |
| info_sel_o | output | 1 | Information page select |
| info_addr_o | output | 11 | Information page offset |
| info_rdata_i | input | 8 | Information page read data |
| flash_sel_o | output | 1 | Flash window select |
| flash_addr_o | output | BANK_W+15 | Physical flash address |
| flash_rdata_i | input | 8 | Flash read data |

## Verification
The main port is driven with a table of addresses placed at both edges of every window and of every hole. Each entry is checked for its select, local address, write enable and returned byte, which separates an off-by-one at a window boundary from a wrong region. Writes to every writable window are followed by reads of the same address, and writes to the information page and to flash are followed by reads that must return the original byte, so a dropped write and a landed write give different results. The fixed flash address 0xC001 is read under all eight bank values, which shows whether the bank bits reach the flash address. Back-to-back reads into different regions, ending in a hole, show that the registered region follows each request rather than the previous one. The internal-data port is cross-checked against main-port accesses at the aliased SRAM addresses.

// File: rtl/xdec_pkg.sv
`timescale 1ns/1ps
package xdec_pkg;
  localparam int DW      = 8;
  localparam int AW      = 16;
  localparam int PER_AW  = 10;
  localparam int SFR_AW  = 7;
  localparam int INFO_AW = 11;
  localparam int FOFF_W  = 15;
  localparam int IDAT_AW = 8;

  // upper address bits that identify each fixed window
  localparam logic [AW-1-PER_AW:0]  PER_TAG  = 6'b011000;
  localparam logic [AW-1-SFR_AW:0]  SFR_TAG  = 9'b0111_0000_1;
  localparam logic [AW-1-INFO_AW:0] INFO_TAG = 5'b01111;

  typedef enum logic [2:0] {
    RGN_NONE  = 3'd0,
    RGN_SRAM  = 3'd1,
    RGN_PER   = 3'd2,
    RGN_SFR   = 3'd3,
    RGN_INFO  = 3'd4,
    RGN_FLASH = 3'd5
  } region_e;
endpackage

// File: rtl/xdec_region_decode.sv
`timescale 1ns/1ps
module xdec_region_decode
  import xdec_pkg::*;
#(
  parameter int SRAM_SIZE = 8192
) (
  input  logic [AW-1:0] addr_i,
  output region_e       region_o
);
  localparam logic [AW-1:0] SRAM_END = AW'(SRAM_SIZE);

  always_comb begin
    if (addr_i[AW-1])                                   region_o = RGN_FLASH;
    else if (addr_i < SRAM_END)                         region_o = RGN_SRAM;
    else if (addr_i[AW-1 -: (AW-PER_AW)]  == PER_TAG)   region_o = RGN_PER;
    else if (addr_i[AW-1 -: (AW-SFR_AW)]  == SFR_TAG)   region_o = RGN_SFR;
    else if (addr_i[AW-1 -: (AW-INFO_AW)] == INFO_TAG)  region_o = RGN_INFO;
    else                                                region_o = RGN_NONE;
  end
endmodule

// File: rtl/xdec_rd_return.sv
`timescale 1ns/1ps
module xdec_rd_return
  import xdec_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_req_i,
  input  region_e       region_i,
  input  logic [DW-1:0] sram_rdata_i,
  input  logic [DW-1:0] per_rdata_i,
  input  logic [DW-1:0] sfr_rdata_i,
  input  logic [DW-1:0] info_rdata_i,
  input  logic [DW-1:0] flash_rdata_i,
  output logic          rvalid_o,
  output logic [DW-1:0] rdata_o
);
  region_e rgn_q;
  logic    vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rgn_q <= RGN_NONE;
      vld_q <= 1'b0;
    end else begin
      vld_q <= rd_req_i;
      if (rd_req_i) rgn_q <= region_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (vld_q) begin
      case (rgn_q)
        RGN_SRAM:  rdata_o = sram_rdata_i;
        RGN_PER:   rdata_o = per_rdata_i;
        RGN_SFR:   rdata_o = sfr_rdata_i;
        RGN_INFO:  rdata_o = info_rdata_i;
        RGN_FLASH: rdata_o = flash_rdata_i;
        default:   rdata_o = '0;
      endcase
    end
  end

  assign rvalid_o = vld_q;
endmodule

// File: rtl/xdec_idata_alias.sv
`timescale 1ns/1ps
module xdec_idata_alias
  import xdec_pkg::*;
#(
  parameter int SRAM_SIZE = 8192,
  parameter int SRAM_AW   = 13
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               idat_req_i,
  input  logic               idat_we_i,
  input  logic [IDAT_AW-1:0] idat_addr_i,
  input  logic [DW-1:0]      idat_wdata_i,
  output logic               idat_rvalid_o,
  output logic [DW-1:0]      idat_rdata_o,
  output logic               sram_b_sel_o,
  output logic               sram_b_we_o,
  output logic [SRAM_AW-1:0] sram_b_addr_o,
  output logic [DW-1:0]      sram_b_wdata_o,
  input  logic [DW-1:0]      sram_b_rdata_i
);
  localparam logic [SRAM_AW-1:0] IBASE = SRAM_AW'(SRAM_SIZE - (1 << IDAT_AW));

  logic vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_q <= 1'b0;
    else         vld_q <= idat_req_i & ~idat_we_i;
  end

  assign sram_b_sel_o   = idat_req_i;
  assign sram_b_we_o    = idat_req_i & idat_we_i;
  assign sram_b_addr_o  = IBASE + SRAM_AW'(idat_addr_i);
  assign sram_b_wdata_o = idat_wdata_i;
  assign idat_rvalid_o  = vld_q;
  assign idat_rdata_o   = vld_q ? sram_b_rdata_i : '0;
endmodule

// File: rtl/data_space_decoder.sv
`timescale 1ns/1ps
module data_space_decoder
  import xdec_pkg::*;
#(
  parameter  int SRAM_SIZE = 8192,
  parameter  int BANK_W    = 3,
  localparam int SRAM_AW   = $clog2(SRAM_SIZE),
  localparam int FLASH_AW  = BANK_W + FOFF_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [AW-1:0]       addr_i,
  input  logic [DW-1:0]       wdata_i,
  input  logic [BANK_W-1:0]   bank_i,
  output logic                rvalid_o,
  output logic [DW-1:0]       rdata_o,
  input  logic                idat_req_i,
  input  logic                idat_we_i,
  input  logic [IDAT_AW-1:0]  idat_addr_i,
  input  logic [DW-1:0]       idat_wdata_i,
  output logic                idat_rvalid_o,
  output logic [DW-1:0]       idat_rdata_o,
  output logic [DW-1:0]       wdata_o,
  output logic                sram_sel_o,
  output logic                sram_we_o,
  output logic [SRAM_AW-1:0]  sram_addr_o,
  input  logic [DW-1:0]       sram_rdata_i,
  output logic                sram_b_sel_o,
  output logic                sram_b_we_o,
  output logic [SRAM_AW-1:0]  sram_b_addr_o,
  output logic [DW-1:0]       sram_b_wdata_o,
  input  logic [DW-1:0]       sram_b_rdata_i,
  output logic                per_sel_o,
  output logic                per_we_o,
  output logic [PER_AW-1:0]   per_addr_o,
  input  logic [DW-1:0]       per_rdata_i,
  output logic                sfr_sel_o,
  output logic                sfr_we_o,
  output logic [SFR_AW-1:0]   sfr_addr_o,
  input  logic [DW-1:0]       sfr_rdata_i,
  output logic                info_sel_o,
  output logic [INFO_AW-1:0]  info_addr_o,
  input  logic [DW-1:0]       info_rdata_i,
  output logic                flash_sel_o,
  output logic [FLASH_AW-1:0] flash_addr_o,
  input  logic [DW-1:0]       flash_rdata_i
);
  // SRAM must stay below the peripheral window and hold the internal-data alias
  generate
    if (SRAM_SIZE > 'h6000 || SRAM_SIZE < (1 << IDAT_AW)) begin : g_bad_sram_size
      $error("data_space_decoder: SRAM_SIZE out of range");
    end
  endgenerate

  region_e rgn;
  logic    rd_req;

  xdec_region_decode #(.SRAM_SIZE(SRAM_SIZE)) u_decode (
    .addr_i   (addr_i),
    .region_o (rgn)
  );

  // read-only regions are selected by reads only; their writes vanish here
  assign sram_sel_o  = req_i & (rgn == RGN_SRAM);
  assign per_sel_o   = req_i & (rgn == RGN_PER);
  assign sfr_sel_o   = req_i & (rgn == RGN_SFR);
  assign info_sel_o  = req_i & ~we_i & (rgn == RGN_INFO);
  assign flash_sel_o = req_i & ~we_i & (rgn == RGN_FLASH);

  assign sram_we_o = sram_sel_o & we_i;
  assign per_we_o  = per_sel_o  & we_i;
  assign sfr_we_o  = sfr_sel_o  & we_i;

  assign sram_addr_o  = addr_i[SRAM_AW-1:0];
  assign per_addr_o   = addr_i[PER_AW-1:0];
  assign sfr_addr_o   = addr_i[SFR_AW-1:0];
  assign info_addr_o  = addr_i[INFO_AW-1:0];
  assign flash_addr_o = {bank_i, addr_i[FOFF_W-1:0]};
  assign wdata_o      = wdata_i;

  assign rd_req = req_i & ~we_i;

  xdec_rd_return u_rd_return (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .rd_req_i      (rd_req),
    .region_i      (rgn),
    .sram_rdata_i  (sram_rdata_i),
    .per_rdata_i   (per_rdata_i),
    .sfr_rdata_i   (sfr_rdata_i),
    .info_rdata_i  (info_rdata_i),
    .flash_rdata_i (flash_rdata_i),
    .rvalid_o      (rvalid_o),
    .rdata_o       (rdata_o)
  );

  xdec_idata_alias #(.SRAM_SIZE(SRAM_SIZE), .SRAM_AW(SRAM_AW)) u_idata (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .idat_req_i     (idat_req_i),
    .idat_we_i      (idat_we_i),
    .idat_addr_i    (idat_addr_i),
    .idat_wdata_i   (idat_wdata_i),
    .idat_rvalid_o  (idat_rvalid_o),
    .idat_rdata_o   (idat_rdata_o),
    .sram_b_sel_o   (sram_b_sel_o),
    .sram_b_we_o    (sram_b_we_o),
    .sram_b_addr_o  (sram_b_addr_o),
    .sram_b_wdata_o (sram_b_wdata_o),
    .sram_b_rdata_i (sram_b_rdata_i)
  );
endmodule

// File: rtl/xdec_checker.sv
`timescale 1ns/1ps
module xdec_checker #(
  parameter  int SRAM_SIZE = 8192,
  parameter  int BANK_W    = 3,
  localparam int SRAM_AW   = $clog2(SRAM_SIZE)
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  req_i,
  input logic                  we_i,
  input logic [15:0]           addr_i,
  input logic                  idat_req_i,
  input logic [7:0]            idat_addr_i,
  input logic                  rvalid_o,
  input logic [7:0]            rdata_o,
  input logic                  sram_sel_o,
  input logic                  sram_we_o,
  input logic                  per_sel_o,
  input logic                  per_we_o,
  input logic                  sfr_sel_o,
  input logic                  sfr_we_o,
  input logic                  info_sel_o,
  input logic                  flash_sel_o,
  input logic [BANK_W+14:0]    flash_addr_o,
  input logic                  sram_b_sel_o,
  input logic [SRAM_AW-1:0]    sram_b_addr_o
);
  localparam logic [15:0]        SEND  = 16'(SRAM_SIZE);
  localparam logic [SRAM_AW-1:0] IBASE = SRAM_AW'(SRAM_SIZE - 256);

  logic hole;
  assign hole = (addr_i >= SEND    && addr_i < 16'h6000) ||
                (addr_i >= 16'h6400 && addr_i < 16'h7080) ||
                (addr_i >= 16'h7100 && addr_i < 16'h7800);

  AST_SINGLE_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({sram_sel_o, per_sel_o, sfr_sel_o, info_sel_o, flash_sel_o})); // R10

  AST_SRAM_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sram_sel_o |-> (req_i && addr_i < SEND)); // R1

  AST_RO_WRITE_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i >= 16'h7800) |->
      !(sram_we_o || per_we_o || sfr_we_o || info_sel_o || flash_sel_o)); // R7

  AST_HOLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && hole) |=> (rvalid_o && rdata_o == 8'h00)); // R6

  AST_RD_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i) |=> rvalid_o); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> (!rvalid_o && rdata_o == 8'h00)); // R9

  AST_FLASH_OFFSET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flash_sel_o |-> (flash_addr_o[14:0] == addr_i[14:0])); // R5

  AST_IDAT_ALIAS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idat_req_i |-> (sram_b_sel_o && sram_b_addr_o == IBASE + SRAM_AW'(idat_addr_i))); // R8
endmodule

bind data_space_decoder xdec_checker #(.SRAM_SIZE(SRAM_SIZE), .BANK_W(BANK_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .req_i         (req_i),
  .we_i          (we_i),
  .addr_i        (addr_i),
  .idat_req_i    (idat_req_i),
  .idat_addr_i   (idat_addr_i),
  .rvalid_o      (rvalid_o),
  .rdata_o       (rdata_o),
  .sram_sel_o    (sram_sel_o),
  .sram_we_o     (sram_we_o),
  .per_sel_o     (per_sel_o),
  .per_we_o      (per_we_o),
  .sfr_sel_o     (sfr_sel_o),
  .sfr_we_o      (sfr_we_o),
  .info_sel_o    (info_sel_o),
  .flash_sel_o   (flash_sel_o),
  .flash_addr_o  (flash_addr_o),
  .sram_b_sel_o  (sram_b_sel_o),
  .sram_b_addr_o (sram_b_addr_o)
);

// File: tb/data_space_decoder_tb.sv
`timescale 1ns/1ps
module data_space_decoder_tb;
  localparam int SRAM_SIZE = 8192;
  localparam int SA        = $clog2(SRAM_SIZE);
  localparam int NV        = 26;

  logic clk, rst_n;
  logic req, we;
  logic [15:0] addr;
  logic [7:0]  wdata;
  logic [2:0]  bank;
  logic        rvalid;
  logic [7:0]  rdata;
  logic        ireq, iwe;
  logic [7:0]  iaddr, iwdata;
  logic        irvalid;
  logic [7:0]  irdata;
  logic [7:0]  wdata_t;
  logic        sram_sel, sram_we, sramb_sel, sramb_we;
  logic [SA-1:0] sram_addr, sramb_addr;
  logic [7:0]  sram_rd, sramb_wd, sramb_rd;
  logic        per_sel, per_we, sfr_sel, sfr_we, info_sel, flash_sel;
  logic [9:0]  per_addr;
  logic [6:0]  sfr_addr;
  logic [10:0] info_addr;
  logic [17:0] flash_addr;
  logic [7:0]  per_rd, sfr_rd, info_rd, flash_rd;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  data_space_decoder u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .bank_i(bank), .rvalid_o(rvalid), .rdata_o(rdata),
    .idat_req_i(ireq), .idat_we_i(iwe), .idat_addr_i(iaddr), .idat_wdata_i(iwdata),
    .idat_rvalid_o(irvalid), .idat_rdata_o(irdata), .wdata_o(wdata_t),
    .sram_sel_o(sram_sel), .sram_we_o(sram_we), .sram_addr_o(sram_addr), .sram_rdata_i(sram_rd),
    .sram_b_sel_o(sramb_sel), .sram_b_we_o(sramb_we), .sram_b_addr_o(sramb_addr),
    .sram_b_wdata_o(sramb_wd), .sram_b_rdata_i(sramb_rd),
    .per_sel_o(per_sel), .per_we_o(per_we), .per_addr_o(per_addr), .per_rdata_i(per_rd),
    .sfr_sel_o(sfr_sel), .sfr_we_o(sfr_we), .sfr_addr_o(sfr_addr), .sfr_rdata_i(sfr_rd),
    .info_sel_o(info_sel), .info_addr_o(info_addr), .info_rdata_i(info_rd),
    .flash_sel_o(flash_sel), .flash_addr_o(flash_addr), .flash_rdata_i(flash_rd)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // target models
  logic [7:0] sram_m [SRAM_SIZE];
  logic [7:0] per_m  [1024];
  logic [7:0] sfr_m  [128];
  logic [7:0] ref_sram [SRAM_SIZE];
  logic [7:0] ref_per  [1024];
  logic [7:0] ref_sfr  [128];

  function automatic logic [7:0] info_fn(logic [10:0] a);
    return (a[7:0] + {5'b0, a[10:8]}) ^ 8'hC3;
  endfunction

  function automatic logic [7:0] flash_fn(logic [17:0] a);
    return a[7:0] ^ a[15:8] ^ {a[17:15], 5'b10011};
  endfunction

  always @(posedge clk) begin
    if (sram_sel) begin
      if (sram_we) sram_m[sram_addr] <= wdata_t;
      sram_rd <= sram_m[sram_addr];
    end
    if (sramb_sel) begin
      if (sramb_we) sramb_rd <= sramb_rd;
      if (sramb_we) sram_m[sramb_addr] <= sramb_wd;
      else          sramb_rd <= sram_m[sramb_addr];
    end
    if (per_sel) begin
      if (per_we) per_m[per_addr] <= wdata_t;
      per_rd <= per_m[per_addr];
    end
    if (sfr_sel) begin
      if (sfr_we) sfr_m[sfr_addr] <= wdata_t;
      sfr_rd <= sfr_m[sfr_addr];
    end
    if (info_sel)  info_rd  <= info_fn(info_addr);
    if (flash_sel) flash_rd <= flash_fn(flash_addr);
  end

  // expected behaviour from the requirements
  function automatic bit in_sram(logic [15:0] a);  return 32'(a) < SRAM_SIZE; endfunction
  function automatic bit in_per(logic [15:0] a);   return a >= 16'h6000 && a <= 16'h63FF; endfunction
  function automatic bit in_sfr(logic [15:0] a);   return a >= 16'h7080 && a <= 16'h70FF; endfunction
  function automatic bit in_info(logic [15:0] a);  return a >= 16'h7800 && a <= 16'h7FFF; endfunction
  function automatic bit in_flash(logic [15:0] a); return a >= 16'h8000; endfunction

  function automatic logic [4:0] exp_sel(logic w, logic [15:0] a);
    if (in_sram(a))            return 5'b00001;
    if (in_per(a))             return 5'b00010;
    if (in_sfr(a))             return 5'b00100;
    if (in_info(a) && !w)      return 5'b01000;
    if (in_flash(a) && !w)     return 5'b10000;
    return 5'b00000;
  endfunction

  function automatic string rq_of(logic w, logic [15:0] a);
    if (in_sram(a))  return "R1";
    if (in_per(a))   return "R2";
    if (in_sfr(a))   return "R3";
    if (in_info(a))  return w ? "R7" : "R4";
    if (in_flash(a)) return w ? "R7" : "R5";
    return "R6";
  endfunction

  function automatic logic [7:0] exp_rd(logic [15:0] a);
    if (in_sram(a))  return ref_sram[a[SA-1:0]];
    if (in_per(a))   return ref_per[a[9:0]];
    if (in_sfr(a))   return ref_sfr[a[6:0]];
    if (in_info(a))  return info_fn(a[10:0]);
    if (in_flash(a)) return flash_fn({bank, a[14:0]});
    return 8'h00;
  endfunction

  task automatic chk(string rq, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [4:0] act_sel();
    return {flash_sel, info_sel, sfr_sel, per_sel, sram_sel};
  endfunction

  task automatic do_acc(logic w, logic [15:0] a, logic [7:0] d);
    string rq;
    logic [7:0] e;
    logic [4:0] es;
    rq = rq_of(w, a);
    e  = exp_rd(a);
    es = exp_sel(w, a);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d;
    #1;
    chk(rq, "select", 32'(act_sel()), 32'(es));
    chk(rq, "write enables", 32'({sfr_we, per_we, sram_we}), 32'(w ? es[2:0] : 3'b000));
    case (es)
      5'b00001: chk(rq, "sram addr",  32'(sram_addr),  32'(a[SA-1:0]));
      5'b00010: chk(rq, "per addr",   32'(per_addr),   32'(a[9:0]));
      5'b00100: chk(rq, "sfr addr",   32'(sfr_addr),   32'(a[6:0]));
      5'b01000: chk(rq, "info addr",  32'(info_addr),  32'(a[10:0]));
      5'b10000: chk(rq, "flash addr", 32'(flash_addr), 32'({bank, a[14:0]}));
      default: ;
    endcase
    if (w && es[2:0] != 3'b000) chk(rq, "wdata", 32'(wdata_t), 32'(d));
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    if (!w) begin
      chk(rq, "rvalid", 32'(rvalid), 32'd1);
      chk(rq, "rdata", 32'(rdata), 32'(e));
    end else begin
      chk("R9", "quiet after write", 32'({rvalid, rdata}), 32'd0);
      if (in_sram(a))     ref_sram[a[SA-1:0]] = d;
      else if (in_per(a)) ref_per[a[9:0]] = d;
      else if (in_sfr(a)) ref_sfr[a[6:0]] = d;
    end
  endtask

  task automatic do_idat(logic w, logic [7:0] a, logic [7:0] d);
    logic [SA-1:0] ea;
    logic [7:0] e;
    ea = SA'(SRAM_SIZE - 256 + 32'(a));
    e  = ref_sram[ea];
    @(negedge clk);
    ireq = 1'b1; iwe = w; iaddr = a; iwdata = d;
    #1;
    chk("R8", "port b select", 32'(sramb_sel), 32'd1);
    chk("R8", "port b addr", 32'(sramb_addr), 32'(ea));
    chk("R8", "port b we", 32'(sramb_we), 32'(w));
    @(negedge clk);
    ireq = 1'b0; iwe = 1'b0;
    if (!w) begin
      chk("R8", "idat rvalid", 32'(irvalid), 32'd1);
      chk("R8", "idat rdata", 32'(irdata), 32'(e));
    end else begin
      ref_sram[ea] = d;
    end
  endtask

  // {we, addr, wdata}
  localparam logic [24:0] VEC [NV] = '{
    {1'b1, 16'h0000, 8'hA5}, {1'b0, 16'h0000, 8'h00},
    {1'b1, 16'h1FFF, 8'h3C}, {1'b0, 16'h1FFF, 8'h00},
    {1'b0, 16'h2000, 8'h00}, {1'b1, 16'h2000, 8'h77},
    {1'b0, 16'h5FFF, 8'h00}, {1'b1, 16'h6000, 8'h11},
    {1'b0, 16'h6000, 8'h00}, {1'b1, 16'h63FF, 8'h22},
    {1'b0, 16'h63FF, 8'h00}, {1'b0, 16'h6400, 8'h00},
    {1'b0, 16'h707F, 8'h00}, {1'b1, 16'h7080, 8'h44},
    {1'b0, 16'h7080, 8'h00}, {1'b0, 16'h70FF, 8'h00},
    {1'b0, 16'h7100, 8'h00}, {1'b0, 16'h77FF, 8'h00},
    {1'b0, 16'h7800, 8'h00}, {1'b0, 16'h7FFF, 8'h00},
    {1'b1, 16'h7800, 8'h99}, {1'b0, 16'h7800, 8'h00},
    {1'b0, 16'h8000, 8'h00}, {1'b0, 16'hFFFF, 8'h00},
    {1'b1, 16'h8123, 8'h55}, {1'b0, 16'h8123, 8'h00}
  };

  initial begin
    for (int i = 0; i < SRAM_SIZE; i++) begin
      sram_m[SA'(i)]   = 8'(i * 7 + 1);
      ref_sram[SA'(i)] = 8'(i * 7 + 1);
    end
    for (int i = 0; i < 1024; i++) begin
      per_m[10'(i)]   = 8'(i) ^ 8'h5A;
      ref_per[10'(i)] = 8'(i) ^ 8'h5A;
    end
    for (int i = 0; i < 128; i++) begin
      sfr_m[7'(i)]   = 8'(i * 3) ^ 8'hE1;
      ref_sfr[7'(i)] = 8'(i * 3) ^ 8'hE1;
    end
    sram_rd = 8'h00; sramb_rd = 8'h00; per_rd = 8'h00; sfr_rd = 8'h00;
    info_rd = 8'hEE; flash_rd = 8'hEE;
    rst_n = 1'b0; req = 1'b0; we = 1'b0; addr = 16'h0; wdata = 8'h0; bank = 3'd3;
    ireq = 1'b0; iwe = 1'b0; iaddr = 8'h0; iwdata = 8'h0;

    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10", "reset rvalid/rdata", 32'({rvalid, rdata}), 32'd0);
    chk("R10", "reset idat rvalid/rdata", 32'({irvalid, irdata}), 32'd0);
    chk("R10", "no select while idle", 32'(act_sel()), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10", "idle after reset", 32'({rvalid, rdata}), 32'd0);

    for (int i = 0; i < NV; i++)
      do_acc(VEC[i][24], VEC[i][23:8], VEC[i][7:0]);

    // R5: every bank at one window address
    for (int b = 0; b < 8; b++) begin
      bank = 3'(b);
      do_acc(1'b0, 16'hC001, 8'h00);
    end
    bank = 3'd3;

    // R9: back-to-back reads across regions, ending in a hole
    begin
      logic [7:0] e0, e1;
      e0 = exp_rd(16'h0000);
      e1 = exp_rd(16'h7801);
      @(negedge clk); req = 1'b1; we = 1'b0; addr = 16'h0000;
      @(negedge clk); addr = 16'h7801;
      chk("R9", "b2b first rdata", 32'({rvalid, rdata}), 32'({1'b1, e0}));
      @(negedge clk); addr = 16'h6400;
      chk("R9", "b2b second rdata", 32'({rvalid, rdata}), 32'({1'b1, e1}));
      @(negedge clk); req = 1'b0;
      chk("R6", "b2b hole rdata", 32'({rvalid, rdata}), 32'({1'b1, 8'h00}));
      @(negedge clk);
      chk("R9", "b2b idle after", 32'({rvalid, rdata}), 32'd0);
    end

    // R8: internal-data alias, crossed with the main port
    do_idat(1'b1, 8'h00, 8'hC7);
    do_acc(1'b0, 16'h1F00, 8'h00);
    do_acc(1'b1, 16'h1FFE, 8'h6D);
    do_idat(1'b0, 8'hFE, 8'h00);
    do_idat(1'b0, 8'hFF, 8'h00);
    chk("R8", "alias of top byte", 32'(ref_sram[SA'(SRAM_SIZE - 1)]), 32'h3C);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule